// File: doc/BRIEF.md
# Continuous Pin-State Streamer

This block is the slave-side command engine for an endless pin-state read on a single-wire serial bus. It works at the level of bit slots. A bit-timing layer in front of it decodes write slots and read slots and shows each one as a single-cycle strobe. The engine collects an 8-bit command from the write slots. When the command is the streaming code (F5h by default), it begins an unbounded outgoing stream of 8-bit snapshots of an input port. The master pulls the stream one bit per read slot.

The engine samples the port once per data byte. It takes each sample at the moment the preceding byte has been fully handed out. That preceding byte is the command, the previous data byte, or the upper byte of a check word. Each sample is flagged on a strobe output. After every block of 32 data bytes the engine inserts the bitwise complement of a CRC16, so the master can check what it received. The stream stops only when a bus reset is signalled.

Top module: `pin_stream_slave`

## Requirements
- R1: After power-on reset, and whenever no stream is running, `rd_bit` is 1 and `sample_stb` is 0. Read slots in this state return 1.
- R2: The command byte is taken from 8 write slots, LSB first. Code F5h starts the stream. Any other code makes the block ignore all slots and return 1 on reads until the next bus reset, even if F5h is sent afterwards.
- R3: The write slot that completes F5h captures `pins_in` as data byte 0. `sample_stb` is high for exactly one clock, in the cycle after that slot strobe.
- R4: Data bytes go out LSB first. `rd_bit` shows the current bit, and each read slot strobe moves to the next bit. `rd_bit` does not change in a cycle that follows no slot strobe and no bus reset.
- R5: The read slot that consumes bit 7 of a data byte, or bit 7 of the upper CRC byte, captures the next data byte from `pins_in` and pulses `sample_stb` for one clock in the following cycle. No other slot pulses it. The captured byte stays fixed while it is shifted out, whatever `pins_in` does.
- R6: After every 32 data bytes, two check bytes follow: first the complement of CRC bits 7:0, then the complement of bits 15:8. The CRC uses x^16+x^15+x^2+1 (reflected constant A001h), starts from zero and shifts each byte in LSB first. No sample is taken at the end of the 32nd data byte or of the low check byte.
- R7: The first check word covers the command byte followed by the first 32 data bytes. Every later check word starts again from zero and covers only its own 32 data bytes.
- R8: The stream has no end. The data/check pattern repeats for as long as read slots arrive.
- R9: A bus reset at any point ends the stream. In the next cycle `rd_bit` is 1, and a new command can then be received.
- R10: Write slots received while the stream runs are ignored and do not disturb the outgoing bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Single-cycle pulse: a bus reset was detected |
| wr_slot | input | 1 | Single-cycle pulse: a write slot was decoded |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_slot | input | 1 | Single-cycle pulse: a read slot was consumed |
| rd_bit | output | 1 | Bit to drive in the current read slot |
| pins_in | input | 8 | Port state to be sampled |
| sample_stb | output | 1 | One-clock pulse marking each port sample |

## Verification
A wrong bit counter or byte counter shows up at once at the ports. The strobe appears on the wrong slot within one byte, and the check bytes arrive at a position other than after the 32nd data byte. A fault in the CRC register is silent in the data bytes. It shows only at the end of a block, up to 33 bytes later, when the two check bytes disagree with the value computed arithmetically from the bytes already received. A mode that fails to leave the stream on a bus reset shows in the very next cycle as `rd_bit` not reading 1.

// File: rtl/stream_pkg.sv
package stream_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_STREAM = 2'd1,
        MODE_MUTE   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_DATA   = 2'd0,
        PH_CRC_LO = 2'd1,
        PH_CRC_HI = 2'd2
    } phase_e;

endpackage

// File: rtl/stream_cmd_rx.sv
module stream_cmd_rx #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             slot,
    input  logic             bit_in,
    output logic             done,
    output logic [CMD_W-1:0] byte_out
);
    localparam int CNT_W = $clog2(CMD_W);

    typedef struct packed {
        logic [CMD_W-1:0] shift;
        logic [CNT_W-1:0] cnt;
    } rx_t;

    rx_t rx_d, rx_q;
    logic take;

    always_comb begin
        rx_d     = rx_q;
        take     = enable && slot;
        byte_out = {bit_in, rx_q.shift[CMD_W-1:1]};
        done     = take && (rx_q.cnt == CNT_W'(CMD_W - 1));
        if (clear) begin
            rx_d = '0;
        end else if (take) begin
            rx_d.shift = byte_out;
            rx_d.cnt   = done ? '0 : rx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end
endmodule

// File: rtl/stream_crc16.sv
module stream_crc16 #(
    parameter int             DATA_W = 8,
    parameter int             CRC_W  = 16,
    parameter logic [15:0]    POLY   = 16'hA001
) (
    input  logic [CRC_W-1:0]  seed,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  result
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = seed;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb           = stage[i][0] ^ data[i];
        assign stage[i + 1] = (stage[i] >> 1) ^ (fb ? CRC_W'(POLY) : '0);
    end

    assign result = stage[DATA_W];
endmodule

// File: rtl/pin_stream_slave.sv
module pin_stream_slave
    import stream_pkg::*;
#(
    parameter int          BLOCK_LEN = 32,
    parameter logic [7:0]  CMD_CODE  = 8'hF5,
    parameter logic [15:0] CRC_POLY  = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_slot,
    input  logic              wr_bit,
    input  logic              rd_slot,
    output logic              rd_bit,
    input  logic [BYTE_W-1:0] pins_in,
    output logic              sample_stb
);
    localparam int CNT_W = (BLOCK_LEN > 2) ? $clog2(BLOCK_LEN) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        mode_e              mode;
        phase_e             phase;
        logic [BIT_W-1:0]   bit_idx;
        logic [CNT_W-1:0]   byte_cnt;
        logic [BYTE_W-1:0]  data;
        logic [CRC_W-1:0]   crc;
        logic               stb;
    } st_t;

    localparam st_t RESET_ST = '{
        mode:     MODE_IDLE,
        phase:    PH_DATA,
        bit_idx:  '0,
        byte_cnt: '0,
        data:     '0,
        crc:      '0,
        stb:      1'b0
    };

    st_t st_d, st_q;

    logic               cmd_done;
    logic [BYTE_W-1:0]  cmd_byte;
    logic [CRC_W-1:0]   crc_cmd;
    logic [CRC_W-1:0]   crc_seed;
    logic [CRC_W-1:0]   crc_smp;
    logic               streaming;
    logic               byte_end;
    logic [BYTE_W-1:0]  out_byte;

    stream_cmd_rx #(.CMD_W(BYTE_W)) u_cmd_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (bus_rst),
        .enable   (st_q.mode == MODE_IDLE),
        .slot     (wr_slot),
        .bit_in   (wr_bit),
        .done     (cmd_done),
        .byte_out (cmd_byte)
    );

    // CRC of the command code alone, from a cleared register
    stream_crc16 #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_cmd (
        .seed   ('0),
        .data   (CMD_CODE),
        .result (crc_cmd)
    );

    // CRC update with the byte being captured from the port
    stream_crc16 #(.DATA_W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_smp (
        .seed   (crc_seed),
        .data   (pins_in),
        .result (crc_smp)
    );

    always_comb begin
        if (st_q.mode == MODE_IDLE)      crc_seed = crc_cmd;
        else if (st_q.phase == PH_CRC_HI) crc_seed = '0;
        else                              crc_seed = st_q.crc;
    end

    always_comb begin
        unique case (st_q.phase)
            PH_CRC_LO: out_byte = ~st_q.crc[BYTE_W-1:0];
            PH_CRC_HI: out_byte = ~st_q.crc[CRC_W-1:BYTE_W];
            default:   out_byte = st_q.data;
        endcase
    end

    assign streaming  = (st_q.mode == MODE_STREAM);
    assign rd_bit     = streaming ? out_byte[st_q.bit_idx] : 1'b1;
    assign sample_stb = st_q.stb;
    assign byte_end   = rd_slot && (st_q.bit_idx == BIT_W'(BYTE_W - 1));

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (bus_rst) begin
            st_d = RESET_ST;
        end else begin
            unique case (st_q.mode)
                MODE_IDLE: begin
                    if (cmd_done) begin
                        if (cmd_byte == CMD_CODE) begin
                            st_d.mode     = MODE_STREAM;
                            st_d.phase    = PH_DATA;
                            st_d.bit_idx  = '0;
                            st_d.byte_cnt = '0;
                            st_d.data     = pins_in;
                            st_d.crc      = crc_smp;
                            st_d.stb      = 1'b1;
                        end else begin
                            st_d.mode = MODE_MUTE;
                        end
                    end
                end
                MODE_STREAM: begin
                    if (rd_slot && !byte_end) begin
                        st_d.bit_idx = st_q.bit_idx + 1'b1;
                    end else if (byte_end) begin
                        st_d.bit_idx = '0;
                        unique case (st_q.phase)
                            PH_DATA: begin
                                if (st_q.byte_cnt == CNT_W'(BLOCK_LEN - 1)) begin
                                    st_d.phase = PH_CRC_LO;
                                end else begin
                                    st_d.byte_cnt = st_q.byte_cnt + 1'b1;
                                    st_d.data     = pins_in;
                                    st_d.crc      = crc_smp;
                                    st_d.stb      = 1'b1;
                                end
                            end
                            PH_CRC_LO: begin
                                st_d.phase = PH_CRC_HI;
                            end
                            default: begin
                                st_d.phase    = PH_DATA;
                                st_d.byte_cnt = '0;
                                st_d.data     = pins_in;
                                st_d.crc      = crc_smp;
                                st_d.stb      = 1'b1;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stream_checker.sv
module stream_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic wr_slot,
    input logic rd_slot,
    input logic rd_bit,
    input logic sample_stb,
    input logic streaming
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !streaming |-> rd_bit);

    assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    assert_stb_in_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> streaming);

    assert_stb_after_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(rd_slot || wr_slot));

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_slot && !wr_slot && !bus_rst) |=> $stable(rd_bit));

    assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (!streaming && rd_bit && !sample_stb));
endmodule

bind pin_stream_slave stream_checker u_stream_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .wr_slot    (wr_slot),
    .rd_slot    (rd_slot),
    .rd_bit     (rd_bit),
    .sample_stb (sample_stb),
    .streaming  (streaming)
);

// File: tb/test_pin_stream_slave.sv
`timescale 1ns/1ps
module test_pin_stream_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       wr_slot = 1'b0;
    logic       wr_bit = 1'b0;
    logic       rd_slot = 1'b0;
    logic       rd_bit;
    logic [7:0] pins_in = 8'h00;
    logic       sample_stb;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [15:0] model_crc;
    int          gidx;

    always #2.5 clk = ~clk;

    pin_stream_slave i_pin_stream_slave (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_slot(wr_slot),
        .wr_bit(wr_bit), .rd_slot(rd_slot), .rd_bit(rd_bit),
        .pins_in(pins_in), .sample_stb(sample_stb)
    );

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int g);
        return 8'((g * 37 + 90) ^ (g >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wslot(input logic b, output logic s);
        wr_bit = b; wr_slot = 1'b1;
        @(negedge clk); wr_slot = 1'b0; s = sample_stb;
        @(negedge clk);
    endtask

    task automatic rslot(output logic b, output logic s);
        b = rd_bit; rd_slot = 1'b1;
        @(negedge clk); rd_slot = 1'b0; s = sample_stb;
        @(negedge clk);
        chk(sample_stb == 1'b0, "R3 strobe width", sample_stb, 0);
    endtask

    task automatic send_cmd(input logic [7:0] c, input bit expect_stb, input string req);
        logic s;
        for (int i = 0; i < 8; i++) begin
            wslot(c[i], s);
            chk(s == (expect_stb && i == 7), req, s, expect_stb && i == 7);
        end
    endtask

    task automatic pulse_bus_rst();
        bus_rst = 1'b1; @(negedge clk); bus_rst = 1'b0;
        chk(rd_bit == 1'b1, "R9 rd_bit after bus reset", rd_bit, 1);
        @(negedge clk);
    endtask

    // read one byte; junk on the pins mid-byte, next value before the last slot
    task automatic read_byte(output logic [7:0] v, input bit expect_stb,
                             input logic [7:0] next_pins, input string req);
        logic b, s;
        for (int i = 0; i < 8; i++) begin
            if (i == 3) pins_in = ~next_pins ^ 8'h3C;
            if (i == 6) pins_in = next_pins;
            rslot(b, s);
            v[i] = b;
            chk(s == (expect_stb && i == 7), req, s, expect_stb && i == 7);
        end
    endtask

    // read one full block plus its check word, starting with data index gidx
    task automatic read_block(input bit after_cmd, input string tag);
        logic [7:0] v;
        model_crc = after_cmd ? crc_upd(16'h0000, 8'hF5) : 16'h0000;
        for (int k = 0; k < 32; k++) begin
            read_byte(v, k != 31, pat(gidx + 1), "R5 strobe at byte end");
            chk(v == pat(gidx), {"R4 R5 data byte ", tag}, v, pat(gidx));
            model_crc = crc_upd(model_crc, pat(gidx));
            gidx++;
        end
        read_byte(v, 1'b0, pat(gidx), "R6 no strobe after low check byte");
        chk(v == ~model_crc[7:0], {"R6 R7 check low ", tag}, v, ~model_crc[7:0]);
        read_byte(v, 1'b1, pat(gidx), "R5 strobe after high check byte");
        chk(v == ~model_crc[15:8], {"R6 R7 check high ", tag}, v, ~model_crc[15:8]);
    endtask

    initial begin
        logic b, s;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk(rd_bit == 1'b1 && sample_stb == 1'b0, "R1 reset state", {rd_bit, sample_stb}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rslot(b, s);
            chk(b == 1'b1 && s == 1'b0, "R1 idle read", {b, s}, 2);
        end

        // wrong command, then the right one while muted
        send_cmd(8'hF0, 1'b0, "R2 no strobe on other code");
        send_cmd(8'hF5, 1'b0, "R2 muted until bus reset");
        for (int i = 0; i < 16; i++) begin
            rslot(b, s);
            chk(b == 1'b1 && s == 1'b0, "R2 muted read", {b, s}, 2);
        end
        pulse_bus_rst();

        // stream three blocks
        gidx = 0;
        pins_in = pat(0);
        send_cmd(8'hF5, 1'b1, "R3 strobe on command end");
        pins_in = pat(1);
        read_block(1'b1, "block0");
        // R10: write slots during the stream are ignored
        for (int i = 0; i < 8; i++) begin
            wslot(i[0], s);
            chk(s == 1'b0, "R10 no strobe on write slot", s, 0);
        end
        read_block(1'b0, "block1 R7");
        read_block(1'b0, "block2 R8");

        // R9: bus reset in the middle of a byte
        for (int i = 0; i < 5; i++) rslot(b, s);
        pulse_bus_rst();
        for (int i = 0; i < 8; i++) begin
            rslot(b, s);
            chk(b == 1'b1 && s == 1'b0, "R9 read after bus reset", {b, s}, 2);
        end

        // restart: first check word again includes the command
        gidx = 100;
        pins_in = pat(100);
        send_cmd(8'hF5, 1'b1, "R9 restart strobe");
        pins_in = pat(101);
        read_block(1'b1, "restart R9");
        read_byte(v, 1'b1, pat(gidx + 1), "R8 continues");
        chk(v == pat(gidx), "R8 data after restart block", v, pat(gidx));

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule